// File: doc/BRIEF.md
# Two-Frame Retiming Elastic Store

This block carries a serial 2.048 Mbit/s bit stream from a write clock domain into a read clock domain through a 512-bit store. That is room for two 256-bit frames. Each domain advances its own pointer on its own enable, so the bench or the surrounding logic can model gapped or drifting clocks. Write-pointer positions cross into the read domain as Gray code through a two-register synchroniser.

In framed mode the read side keeps a guard band from the write pointer. When a read finds the store nearly empty or nearly full, the read pointer jumps by one whole frame in the same step as its normal advance. This is a controlled slip, and a one-cycle slip pulse marks it. The slips are counted over windows of 4096 reads. If more slips than a programmable limit fall in one window, an inoperability alarm is raised, and it reaches the interrupt output unless it is masked. In unframed mode both pointers wrap freely with no slips at all, and a flag tells downstream logic that frame-derived indications are not valid. A bypass select sends the input bit straight to the output.

Top module: `e1_retime_store`

## Requirements
- R1: After reset the store contents are all zero and the read pointer sits 256 bits behind the write pointer, so the first 256 reads return 0. After reset `slip_pulse`, `alarm_irq` and `rd_bit` are 0.
- R2: In framed mode, with one write and one read per cycle, the output taken on read k equals the bit written on write k-256. No slip occurs.
- R3: In framed mode, a read that sees a fill of 8 or less advances the read pointer by 257 instead of 1, repeating a frame. The fill is the synchronised write count minus the read pointer, modulo 512. `slip_pulse` is high for the cycle after that read.
- R4: In framed mode, a read that sees a fill of 504 or more also advances the read pointer by 257, dropping a frame, and pulses `slip_pulse`. The read that follows returns the bit stored at the jumped-to address.
- R5: In unframed mode no slip ever occurs, the pointers wrap freely, and `frame_info_invalid` is 1. In framed mode it is 0.
- R6: Reads are grouped into windows of 4096, counted from reset. The internal alarm is set on the read that brings the window's slip count above `slip_limit`. On the last read of a window, the alarm takes the value of whether that window, including any slip on that read, exceeded the limit.
- R7: `alarm_irq` is the alarm when `alarm_mask` is 0, and is 0 when `alarm_mask` is 1.
- R8: With `cfg_bypass` at 1, `rd_bit` equals `wr_bit` combinationally. With `cfg_bypass` at 0, `rd_bit` is the registered store output.
- R9: The Gray-coded write pointer changes by at most one bit per write clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write domain clock |
| wr_rst_n | input | 1 | Write domain reset, active low |
| wr_en | input | 1 | Store `wr_bit` and advance the write pointer |
| wr_bit | input | 1 | Serial input data |
| rd_clk | input | 1 | Read domain clock |
| rd_rst_n | input | 1 | Read domain reset, active low |
| rd_en | input | 1 | Read one bit and advance the read pointer |
| cfg_unframed | input | 1 | 1 selects free-running unframed mode |
| cfg_bypass | input | 1 | 1 routes `wr_bit` straight to `rd_bit` |
| alarm_mask | input | 1 | 1 blocks the alarm from `alarm_irq` |
| slip_limit | input | 5 | Largest slip count per window that raises no alarm |
| rd_bit | output | 1 | Serial output data |
| slip_pulse | output | 1 | One-cycle pulse after each controlled slip |
| alarm_irq | output | 1 | Masked inoperability alarm |
| frame_info_invalid | output | 1 | Frame-derived indications not valid (unframed mode) |

## Verification
A slip and the closing read of a 4096-read window can land on the same read. That read decides whether the alarm is set for the next window. The bench writes 7 bits first and then reads continuously with writes stopped, which places the sixteenth slip exactly on read 4095. With the limit at 15, the alarm must be clear after read 4094 and set after read 4095. A design that lost the closing slip, or cleared the count first, would leave it clear.

// File: rtl/e1_retime_store.sv
module e1_retime_store #(
  parameter int DEPTH  = 512,
  parameter int FRAME  = 256,
  parameter int GUARD  = 8,
  parameter int WINDOW = 4096,
  parameter int LIMW   = 5
) (
  input  logic            wr_clk,
  input  logic            wr_rst_n,
  input  logic            wr_en,
  input  logic            wr_bit,
  input  logic            rd_clk,
  input  logic            rd_rst_n,
  input  logic            rd_en,
  input  logic            cfg_unframed,
  input  logic            cfg_bypass,
  input  logic            alarm_mask,
  input  logic [LIMW-1:0] slip_limit,
  output logic            rd_bit,
  output logic            slip_pulse,
  output logic            alarm_irq,
  output logic            frame_info_invalid
);
  localparam int AW = $clog2(DEPTH);
  localparam int WW = $clog2(WINDOW);
  localparam int CW = LIMW + 1;
  localparam logic [AW-1:0] GLO  = AW'(GUARD);
  localparam logic [AW-1:0] GHI  = AW'(DEPTH - GUARD);
  localparam logic [AW-1:0] JUMP = AW'(FRAME + 1);
  localparam logic [AW-1:0] RST_RPTR = AW'(FRAME);

  function automatic logic [AW-1:0] g2b(input logic [AW-1:0] g);
    logic [AW-1:0] b;
    b[AW-1] = g[AW-1];
    for (int i = AW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DEPTH-1:0] mem;
  logic [AW-1:0]    wptr, wptr_inc, wgray;
  logic [AW-1:0]    sync1, sync2, wsync_bin, rptr, fill;
  logic             rd_q, slip, alarm;
  logic [WW-1:0]    win;
  logic [CW-1:0]    cnt, cnt_nxt;
  logic             win_end, exceed;

  assign wptr_inc = wptr + 1'b1;

  always_ff @(posedge wr_clk or negedge wr_rst_n) begin
    if (!wr_rst_n) begin
      mem   <= '0;
      wptr  <= '0;
      wgray <= '0;
    end else if (wr_en) begin
      mem[wptr] <= wr_bit;
      wptr      <= wptr_inc;
      wgray     <= wptr_inc ^ (wptr_inc >> 1);
    end
  end

  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= wgray;
      sync2 <= sync1;
    end
  end

  assign wsync_bin = g2b(sync2);
  assign fill      = wsync_bin - rptr;
  assign slip      = rd_en && !cfg_unframed && (fill <= GLO || fill >= GHI);
  assign win_end   = rd_en && (win == {WW{1'b1}});
  assign cnt_nxt   = (slip && cnt != {CW{1'b1}}) ? cnt + 1'b1 : cnt;
  assign exceed    = cnt_nxt > {1'b0, slip_limit};

  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n) begin
      rptr       <= RST_RPTR;
      rd_q       <= 1'b0;
      slip_pulse <= 1'b0;
      win        <= '0;
      cnt        <= '0;
      alarm      <= 1'b0;
    end else begin
      slip_pulse <= slip;
      if (rd_en) begin
        rd_q <= mem[rptr];
        rptr <= slip ? rptr + JUMP : rptr + 1'b1;
        win  <= win + 1'b1;
      end
      if (win_end) begin
        cnt   <= '0;
        alarm <= exceed;
      end else begin
        cnt <= cnt_nxt;
        if (exceed) alarm <= 1'b1;
      end
    end
  end

  assign rd_bit             = cfg_bypass ? wr_bit : rd_q;
  assign alarm_irq          = alarm && !alarm_mask;
  assign frame_info_invalid = cfg_unframed;
endmodule

module e1_retime_store_chk #(
  parameter int AW   = 9,
  parameter int JUMP = 257
) (
  input logic          wr_clk,
  input logic          wr_rst_n,
  input logic          rd_clk,
  input logic          rd_rst_n,
  input logic          rd_en,
  input logic          cfg_unframed,
  input logic          alarm_mask,
  input logic          slip,
  input logic          slip_pulse,
  input logic          alarm,
  input logic          alarm_irq,
  input logic [AW-1:0] rptr,
  input logic [AW-1:0] wgray
);
  assert_gray_step_R9: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    $onehot0(wgray ^ $past(wgray)));

  assert_slip_jump_R3: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    slip_pulse |-> rptr == $past(rptr) + AW'(JUMP));

  assert_plain_step_R2: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    (rd_en && !slip) |=> rptr == $past(rptr) + 1'b1);

  assert_hold_idle_R2: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    !rd_en |=> $stable(rptr));

  assert_no_slip_unframed_R5: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    slip_pulse |-> !$past(cfg_unframed) && $past(rd_en));

  assert_alarm_on_slip_R6: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    $rose(alarm) |-> slip_pulse);

  assert_irq_masked_R7: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    alarm_mask |-> !alarm_irq);
endmodule

bind e1_retime_store e1_retime_store_chk #(.AW(AW), .JUMP(FRAME + 1)) u_chk (
  .wr_clk(wr_clk), .wr_rst_n(wr_rst_n), .rd_clk(rd_clk), .rd_rst_n(rd_rst_n),
  .rd_en(rd_en), .cfg_unframed(cfg_unframed), .alarm_mask(alarm_mask),
  .slip(slip), .slip_pulse(slip_pulse), .alarm(alarm), .alarm_irq(alarm_irq),
  .rptr(rptr), .wgray(wgray)
);

// File: tb/e1_retime_store_bench.sv
module e1_retime_store_bench;
  logic clk = 1'b0;
  logic rst_n;
  logic wr_en, wr_bit, rd_en, cfg_unframed, cfg_bypass, alarm_mask;
  logic [4:0] slip_limit;
  logic rd_bit, slip_pulse, alarm_irq, frame_info_invalid;
  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  e1_retime_store u_e1_retime_store (
    .wr_clk(clk), .wr_rst_n(rst_n), .wr_en(wr_en), .wr_bit(wr_bit),
    .rd_clk(clk), .rd_rst_n(rst_n), .rd_en(rd_en),
    .cfg_unframed(cfg_unframed), .cfg_bypass(cfg_bypass), .alarm_mask(alarm_mask),
    .slip_limit(slip_limit), .rd_bit(rd_bit), .slip_pulse(slip_pulse),
    .alarm_irq(alarm_irq), .frame_info_invalid(frame_info_invalid)
  );

  // {cfg_bypass, wr_bit, expected rd_bit} with store output held at 0
  localparam logic [2:0] VEC [8] = '{
    3'b1_1_1, 3'b1_0_0, 3'b0_1_0, 3'b1_1_1,
    3'b0_0_0, 3'b1_0_0, 3'b0_1_0, 3'b1_1_1
  };

  function automatic logic pat(int k);
    return ((k * 5) ^ (k >> 2) ^ (k >> 5)) & 1;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(logic we, logic wb, logic re);
    wr_en = we; wr_bit = wb; rd_en = re;
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 0; wr_bit = 0; rd_en = 0;
    cfg_unframed = 0; cfg_bypass = 0; alarm_mask = 0; slip_limit = 5'd4;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int bad;
    do_reset();
    check(rd_bit == 0 && slip_pulse == 0 && alarm_irq == 0, "R1 reset outputs",
          {rd_bit, slip_pulse, alarm_irq}, 0);
    check(frame_info_invalid == 0, "R5 framed flag", frame_info_invalid, 0);

    foreach (VEC[i]) begin
      cfg_bypass = VEC[i][2]; wr_bit = VEC[i][1]; #1;
      check(rd_bit == VEC[i][0], "R8 bypass vector", rd_bit, VEC[i][0]);
    end
    cfg_bypass = 0;

    // R1/R2: equal rates, 256-bit delay
    bad = 0;
    for (int k = 0; k < 768; k++) begin
      cyc(1, pat(k), 1);
      if (rd_bit !== ((k < 256) ? 1'b0 : pat(k - 256)) || slip_pulse) bad++;
      if (k == 255) check(bad == 0, "R1 zero fill first 256 reads", bad, 0);
    end
    check(bad == 0, "R2 delayed data no slip", bad, 0);

    // R4: overfull store drops a frame
    do_reset();
    for (int k = 0; k < 250; k++) cyc(1, pat(k), 0);
    repeat (5) cyc(0, 0, 0);
    cyc(0, 0, 1);
    check(slip_pulse == 1, "R4 slip on full", slip_pulse, 1);
    check(rd_bit == 0, "R4 read before jump", rd_bit, 0);
    cyc(0, 0, 1);
    check(slip_pulse == 0, "R4 single pulse", slip_pulse, 0);
    check(rd_bit == pat(1), "R4 jumped address data", rd_bit, pat(1));

    // R5: unframed never slips
    do_reset();
    cfg_unframed = 1;
    bad = 0;
    for (int n = 0; n < 1000; n++) begin
      cyc(0, 0, 1);
      if (slip_pulse) bad++;
    end
    check(bad == 0, "R5 no slips unframed", bad, 0);
    check(frame_info_invalid == 1, "R5 invalid flag", frame_info_invalid, 1);

    // R3/R6/R7: underrun slips from reset, limit 4
    do_reset();
    bad = 0;
    for (int n = 0; n <= 1272; n++) begin
      cyc(0, 0, 1);
      if (slip_pulse != (n >= 248 && (n - 248) % 256 == 0)) bad++;
      if (n == 248) check(slip_pulse == 1, "R3 first underrun slip", slip_pulse, 1);
      if (n == 1271) check(alarm_irq == 0, "R6 alarm before fifth slip", alarm_irq, 0);
    end
    check(bad == 0, "R3 slip spacing", bad, 0);
    check(alarm_irq == 1, "R6 alarm at fifth slip", alarm_irq, 1);
    alarm_mask = 1; #1;
    check(alarm_irq == 0, "R7 masked", alarm_irq, 0);
    alarm_mask = 0; #1;
    check(alarm_irq == 1, "R7 unmasked", alarm_irq, 1);

    // R6: slip on last read of window, then clearing window
    do_reset();
    slip_limit = 5'd15;
    for (int k = 0; k < 7; k++) cyc(1, 1, 0);
    repeat (5) cyc(0, 0, 0);
    bad = 0;
    for (int n = 0; n < 4096; n++) begin
      cyc(0, 0, 1);
      if (slip_pulse != (n >= 255 && (n - 255) % 256 == 0)) bad++;
      if (n == 4094) check(alarm_irq == 0, "R6 before window close", alarm_irq, 0);
    end
    check(bad == 0, "R3 slips across window", bad, 0);
    check(slip_pulse == 1, "R6 slip on closing read", slip_pulse, 1);
    check(alarm_irq == 1, "R6 closing slip counted", alarm_irq, 1);
    cfg_unframed = 1;
    for (int n = 4096; n < 8192; n++) begin
      cyc(0, 0, 1);
      if (n == 8190) check(alarm_irq == 1, "R6 alarm held in window", alarm_irq, 1);
    end
    check(alarm_irq == 0, "R6 alarm cleared by quiet window", alarm_irq, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule